// File: doc/BRIEF.md
# Memory-Operation Ordering Scoreboard

This block keeps every memory operation that is in flight, in program order, and says for each one whether it may issue under a weak ordering policy. Each operation arrives with a tag and three attribute bits: it may read memory, it may write memory, and it has side effects. From these bits the block classifies the operation. It can be a plain load, a plain store, a load barrier (a read with side effects), a store barrier (a write with side effects) or a full barrier (both of them). A read takes one entry in the load queue and a write takes one entry in the store queue. An operation that does both counts in each queue.

A scheduler places a tag on the query port and gets a combinational ready answer that is computed from the state held at that moment. When the operation completes, the scheduler pulses the retire port with its tag, and the entry leaves both queues. Program age comes from an allocation-order matrix, so the block never compares tag values numerically. Each queue has a size limit set by a parameter. A limit of zero removes the full flag, and only the physical depth then bounds the queue.

Every storage slot runs a two-state machine. SLOT_FREE moves to SLOT_LIVE on the claim transition, which happens when a granted allocation picks the lowest free slot. SLOT_LIVE goes back to SLOT_FREE on the drain transition, which happens when a retire strobe matches the slot's tag.

Top module: `lsq_order_board`

## Requirements
- R1: An operation with the read attribute counts one entry in the load queue and an operation with the write attribute counts one entry in the store queue. An operation with both counts in each. After a granted allocation the matching empty flags are low from the next cycle.
- R2: An allocation with neither the read nor the write attribute is not granted and occupies nothing.
- R3: A write is not ready while any older read or older write is held, whatever the value of `cfg_no_alias`.
- R4: With `cfg_no_alias` low, a read is not ready while any older write is held. With it high, older writes do not hold back a read.
- R5: A read may pass older plain reads, but it is not ready while any older load barrier or full barrier is held.
- R6: A full barrier (read, write and side effects all set) holds back every younger read and every younger write, even with `cfg_no_alias` high, until it is retired.
- R7: A load barrier is itself ready only once no older read remains in the load queue.
- R8: With a non-zero limit, a queue's full flag is high exactly when its occupancy equals the limit. An allocation that needs a full queue is not granted.
- R9: With a limit of zero, the full flag of that queue never rises, and allocation into it is refused once its occupancy reaches the physical depth `DEPTH`.
- R10: A retire strobe removes the tagged entry from every queue on the next cycle. An allocation in the same cycle as a retire is evaluated against the occupancy before the retire, and freed slots can be used again.
- R11: A retire strobe whose tag matches no held entry raises `ret_unknown` in the same cycle and changes no state.
- R12: `qry_ready` is combinational. It is low for a tag that is not held, including a tag whose allocation is in the current cycle, and it reflects that allocation from the next cycle on.
- R13: After reset both queues are empty, neither full flag is set and nothing reports ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_no_alias | input | 1 | 1: reads ignore older writes |
| alc_valid | input | 1 | Allocation request |
| alc_tag | input | TAG_W | Tag of the allocated operation |
| alc_may_load | input | 1 | Operation reads memory |
| alc_may_store | input | 1 | Operation writes memory |
| alc_side_eff | input | 1 | Operation has side effects (barrier) |
| alc_granted | output | 1 | Allocation accepted this cycle |
| qry_tag | input | TAG_W | Tag being asked about |
| qry_ready | output | 1 | Queried operation may issue |
| ret_valid | input | 1 | Retire strobe |
| ret_tag | input | TAG_W | Tag of the completed operation |
| ret_unknown | output | 1 | Retire tag matches no held entry |
| lq_full | output | 1 | Load queue at its limit |
| sq_full | output | 1 | Store queue at its limit |
| lq_empty | output | 1 | Load queue holds nothing |
| sq_empty | output | 1 | Store queue holds nothing |

## Verification
A corrupted age matrix or a corrupted class bit shows up in the same cycle as a wrong `qry_ready` for the affected tag. Because of this, the bench asks about each younger operation both before and after an older one retires. A slot that does not drain, or that drains twice, shows up one cycle after the retire. It appears either as an empty or full flag that does not move, or as an allocation that is refused when it should be granted. Faults in tag matching appear at once on `ret_unknown`.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_LIVE = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic rd;      // occupies the load queue
        logic wr;      // occupies the store queue
        logic rd_bar;  // orders younger reads
        logic wr_bar;  // orders younger writes
    } op_cls_t;

    function automatic op_cls_t classify(input logic may_rd,
                                         input logic may_wr,
                                         input logic side);
        op_cls_t c;
        c.rd     = may_rd;
        c.wr     = may_wr;
        c.rd_bar = may_rd & side;
        c.wr_bar = may_wr & side;
        return c;
    endfunction

endpackage

// File: rtl/lsq_slot.sv
module lsq_slot #(
    parameter int TAG_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  claim_i,
    input  logic                  drain_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  lsq_pkg::op_cls_t      cls_i,
    output logic                  live_o,
    output logic [TAG_W-1:0]      tag_o,
    output lsq_pkg::op_cls_t      cls_o
);
    import lsq_pkg::*;

    slot_state_e      state_q;
    logic [TAG_W-1:0] tag_q;
    op_cls_t          cls_q;

    // State register: claim and drain transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            tag_q   <= '0;
            cls_q   <= '0;
        end else begin
            unique case (state_q)
                SLOT_FREE: begin
                    if (claim_i) begin
                        state_q <= SLOT_LIVE;
                        tag_q   <= tag_i;
                        cls_q   <= cls_i;
                    end
                end
                SLOT_LIVE: begin
                    if (drain_i) begin
                        state_q <= SLOT_FREE;
                        cls_q   <= '0;
                    end
                end
                default: state_q <= SLOT_FREE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        live_o = (state_q == SLOT_LIVE);
        tag_o  = tag_q;
        cls_o  = live_o ? cls_q : '0;
    end

endmodule

// File: rtl/lsq_age_matrix.sv
module lsq_age_matrix #(
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        claim_oh,
    input  logic [N-1:0]        live,
    output logic [N-1:0][N-1:0] older_o   // older_o[i][j]: j is older than i
);
    logic [N-1:0][N-1:0] older_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (claim_oh[k]) begin
                    for (int j = 0; j < N; j++) begin
                        older_q[j][k] <= 1'b0;
                    end
                    older_q[k] <= live;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            older_o[i] = older_q[i] & live;
        end
    end

endmodule

// File: rtl/lsq_ready_eval.sv
module lsq_ready_eval #(
    parameter int N = 8
) (
    input  logic [N-1:0]        live,
    input  logic [N-1:0]        is_rd,
    input  logic [N-1:0]        is_wr,
    input  logic [N-1:0]        is_rd_bar,
    input  logic [N-1:0]        is_wr_bar,
    input  logic [N-1:0][N-1:0] older,
    input  logic                no_alias,
    output logic [N-1:0]        rdy
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic prior_rd, prior_wr, prior_rdb, prior_wrb, blk;
            prior_rd  = |(older[i] & is_rd);
            prior_wr  = |(older[i] & is_wr);
            prior_rdb = |(older[i] & is_rd_bar);
            prior_wrb = |(older[i] & is_wr_bar);
            blk = 1'b0;
            if (is_wr[i]) begin
                blk = blk | prior_rd | prior_wr | prior_wrb;
            end
            if (is_rd[i]) begin
                blk = blk | prior_rdb | (prior_wr & ~no_alias);
                if (is_rd_bar[i]) begin
                    blk = blk | prior_rd;
                end
            end
            rdy[i] = live[i] & ~blk;
        end
    end

endmodule

// File: rtl/lsq_order_board.sv
module lsq_order_board #(
    parameter int TAG_W    = 4,
    parameter int DEPTH    = 4,
    parameter int LQ_LIMIT = 0,
    parameter int SQ_LIMIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_no_alias,
    input  logic             alc_valid,
    input  logic [TAG_W-1:0] alc_tag,
    input  logic             alc_may_load,
    input  logic             alc_may_store,
    input  logic             alc_side_eff,
    output logic             alc_granted,
    input  logic [TAG_W-1:0] qry_tag,
    output logic             qry_ready,
    input  logic             ret_valid,
    input  logic [TAG_W-1:0] ret_tag,
    output logic             ret_unknown,
    output logic             lq_full,
    output logic             sq_full,
    output logic             lq_empty,
    output logic             sq_empty
);
    import lsq_pkg::*;

    localparam int SLOTS  = 2 * DEPTH;
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int LQ_CAP = (LQ_LIMIT == 0) ? DEPTH : LQ_LIMIT;
    localparam int SQ_CAP = (SQ_LIMIT == 0) ? DEPTH : SQ_LIMIT;
    localparam logic [CNT_W-1:0] LQ_CAP_V = CNT_W'(LQ_CAP);
    localparam logic [CNT_W-1:0] SQ_CAP_V = CNT_W'(SQ_CAP);

    op_cls_t          alc_cls;
    logic [SLOTS-1:0] live, claim, drain;
    logic [TAG_W-1:0] slot_tag [SLOTS];
    op_cls_t          slot_cls [SLOTS];
    logic [SLOTS-1:0] v_rd, v_wr, v_rdb, v_wrb, rdy;
    logic [SLOTS-1:0][SLOTS-1:0] older;
    logic [SLOTS-1:0] free_oh, ret_oh, qry_hit;
    logic             free_any, ret_any;
    logic [CNT_W-1:0] lq_cnt, sq_cnt;
    logic             lq_block, sq_block;

    assign alc_cls = classify(alc_may_load, alc_may_store, alc_side_eff);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        lsq_slot #(.TAG_W(TAG_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .claim_i (claim[g]),
            .drain_i (drain[g]),
            .tag_i   (alc_tag),
            .cls_i   (alc_cls),
            .live_o  (live[g]),
            .tag_o   (slot_tag[g]),
            .cls_o   (slot_cls[g])
        );
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            v_rd[i]    = slot_cls[i].rd;
            v_wr[i]    = slot_cls[i].wr;
            v_rdb[i]   = slot_cls[i].rd_bar;
            v_wrb[i]   = slot_cls[i].wr_bar;
            qry_hit[i] = live[i] && (slot_tag[i] == qry_tag);
        end
    end

    lsq_age_matrix #(.N(SLOTS)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .claim_oh (claim),
        .live     (live),
        .older_o  (older)
    );

    lsq_ready_eval #(.N(SLOTS)) u_rdy (
        .live      (live),
        .is_rd     (v_rd),
        .is_wr     (v_wr),
        .is_rd_bar (v_rdb),
        .is_wr_bar (v_wrb),
        .older     (older),
        .no_alias  (cfg_no_alias),
        .rdy       (rdy)
    );

    // Lowest free slot and first matching retire slot
    always_comb begin
        free_oh  = '0;
        free_any = 1'b0;
        ret_oh   = '0;
        ret_any  = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!live[i] && !free_any) begin
                free_oh[i] = 1'b1;
                free_any   = 1'b1;
            end
            if (live[i] && (slot_tag[i] == ret_tag) && !ret_any) begin
                ret_oh[i] = 1'b1;
                ret_any   = 1'b1;
            end
        end
    end

    assign lq_cnt   = CNT_W'($countones(v_rd));
    assign sq_cnt   = CNT_W'($countones(v_wr));
    assign lq_block = (lq_cnt == LQ_CAP_V);
    assign sq_block = (sq_cnt == SQ_CAP_V);

    assign alc_granted = alc_valid && (alc_cls.rd || alc_cls.wr)
                       && !(alc_cls.rd && lq_block)
                       && !(alc_cls.wr && sq_block)
                       && free_any;
    assign claim       = free_oh & {SLOTS{alc_granted}};
    assign drain       = ret_oh & {SLOTS{ret_valid}};
    assign ret_unknown = ret_valid && !ret_any;
    assign qry_ready   = |(rdy & qry_hit);

    assign lq_full  = (LQ_LIMIT != 0) && lq_block;
    assign sq_full  = (SQ_LIMIT != 0) && sq_block;
    assign lq_empty = (lq_cnt == '0);
    assign sq_empty = (sq_cnt == '0);

endmodule

// File: rtl/lsq_order_board_chk.sv
module lsq_order_board_chk #(
    parameter int LQ_LIMIT = 0,
    parameter int SQ_LIMIT = 0,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alc_valid,
    input logic             alc_may_load,
    input logic             alc_may_store,
    input logic             alc_granted,
    input logic             qry_ready,
    input logic             ret_valid,
    input logic             ret_unknown,
    input logic             lq_full,
    input logic             sq_full,
    input logic             lq_empty,
    input logic             sq_empty,
    input logic [CNT_W-1:0] lq_cnt,
    input logic [CNT_W-1:0] sq_cnt
);
    AST_NO_KIND_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        alc_granted |-> (alc_may_load || alc_may_store)); // R2
    AST_LOAD_GRANT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_granted && alc_may_load) |=> !lq_empty); // R1
    AST_STORE_GRANT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_granted && alc_may_store) |=> !sq_empty); // R1
    AST_LQ_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_valid && alc_may_load && lq_full) |-> !alc_granted); // R8
    AST_SQ_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_valid && alc_may_store && sq_full) |-> !alc_granted); // R8
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full |-> !lq_empty) and (sq_full |-> !sq_empty)); // R8
    AST_ZERO_LIMIT_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((LQ_LIMIT == 0) |-> !lq_full) and ((SQ_LIMIT == 0) |-> !sq_full)); // R9
    AST_UNKNOWN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_unknown |-> ret_valid); // R11
    AST_UNKNOWN_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_unknown && !alc_granted) |=> ($stable(lq_cnt) && $stable(sq_cnt))); // R11
    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_empty && sq_empty) |-> !qry_ready); // R12
endmodule

bind lsq_order_board lsq_order_board_chk #(
    .LQ_LIMIT (LQ_LIMIT),
    .SQ_LIMIT (SQ_LIMIT),
    .CNT_W    (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alc_valid     (alc_valid),
    .alc_may_load  (alc_may_load),
    .alc_may_store (alc_may_store),
    .alc_granted   (alc_granted),
    .qry_ready     (qry_ready),
    .ret_valid     (ret_valid),
    .ret_unknown   (ret_unknown),
    .lq_full       (lq_full),
    .sq_full       (sq_full),
    .lq_empty      (lq_empty),
    .sq_empty      (sq_empty),
    .lq_cnt        (lq_cnt),
    .sq_cnt        (sq_cnt)
);

// File: tb/lsq_order_board_tb.sv
`timescale 1ns/1ps
module lsq_order_board_tb;
    localparam int TAG_W = 4;
    localparam int NV    = 26;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_no_alias = 1'b0;
    logic             alc_valid = 1'b0;
    logic [TAG_W-1:0] alc_tag = '0;
    logic             alc_may_load = 1'b0;
    logic             alc_may_store = 1'b0;
    logic             alc_side_eff = 1'b0;
    logic             alc_granted;
    logic [TAG_W-1:0] qry_tag = '0;
    logic             qry_ready;
    logic             ret_valid = 1'b0;
    logic [TAG_W-1:0] ret_tag = '0;
    logic             ret_unknown;
    logic             lq_full, sq_full, lq_empty, sq_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lsq_order_board #(.TAG_W(TAG_W), .DEPTH(4), .LQ_LIMIT(2), .SQ_LIMIT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_no_alias(cfg_no_alias),
        .alc_valid(alc_valid), .alc_tag(alc_tag), .alc_may_load(alc_may_load),
        .alc_may_store(alc_may_store), .alc_side_eff(alc_side_eff),
        .alc_granted(alc_granted), .qry_tag(qry_tag), .qry_ready(qry_ready),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_unknown(ret_unknown),
        .lq_full(lq_full), .sq_full(sq_full), .lq_empty(lq_empty), .sq_empty(sq_empty)
    );

    // {req[14:11], kind[10:9] (0 alloc, 1 retire, 2 query), tag[8:5], rd, wr, side, no_alias, expect}
    localparam logic [14:0] VEC [NV] = '{
        {4'd1,  2'd0, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 store T1
        {4'd1,  2'd0, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 load T2
        {4'd4,  2'd2, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 blocked by T1
        {4'd4,  2'd2, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 no-alias passes
        {4'd3,  2'd2, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 oldest store
        {4'd1,  2'd0, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 store T3
        {4'd3,  2'd2, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 store waits
        {4'd8,  2'd0, 4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 load barrier T4
        {4'd8,  2'd0, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 LQ at limit
        {4'd7,  2'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 older load T2
        {4'd10, 2'd1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 retire T2
        {4'd7,  2'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 barrier oldest
        {4'd4,  2'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 barrier vs stores
        {4'd10, 2'd0, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 slot reuse
        {4'd5,  2'd2, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 behind barrier
        {4'd10, 2'd1, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 retire T4
        {4'd5,  2'd2, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 barrier gone
        {4'd11, 2'd1, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 unknown tag
        {4'd1,  2'd0, 4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 load T6
        {4'd5,  2'd2, 4'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 passes plain load
        {4'd2,  2'd0, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 no attributes
        {4'd12, 2'd2, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R12 absent tag
        {4'd10, 2'd1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        {4'd10, 2'd1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        {4'd10, 2'd1, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        {4'd10, 2'd1, 4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R10
    };

    task automatic check(input int req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alc_valid = 1'b0;
        ret_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_alloc(input int req, input logic [TAG_W-1:0] t,
                            input logic rd, input logic wr, input logic se, input logic exp);
        @(negedge clk);
        idle();
        alc_valid = 1'b1; alc_tag = t;
        alc_may_load = rd; alc_may_store = wr; alc_side_eff = se;
        #1 check(req, "alc_granted", alc_granted, exp);
    endtask

    task automatic do_query(input int req, input logic [TAG_W-1:0] t,
                            input logic na, input logic exp);
        @(negedge clk);
        idle();
        cfg_no_alias = na; qry_tag = t;
        #1 check(req, "qry_ready", qry_ready, exp);
    endtask

    task automatic do_retire(input int req, input logic [TAG_W-1:0] t, input logic exp);
        @(negedge clk);
        idle();
        ret_valid = 1'b1; ret_tag = t;
        #1 check(req, "ret_unknown", ret_unknown, exp);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R0 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R13 reset state
        check(13, "lq_empty", lq_empty, 1'b1);
        check(13, "sq_empty", sq_empty, 1'b1);
        check(13, "lq_full", lq_full, 1'b0);
        check(13, "sq_full", sq_full, 1'b0);
        check(13, "qry_ready", qry_ready, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VEC[i];
            case (v[10:9])
                2'd0:    do_alloc(int'(v[14:11]), v[8:5], v[4], v[3], v[2], v[0]);
                2'd1:    do_retire(int'(v[14:11]), v[8:5], v[0]);
                default: do_query(int'(v[14:11]), v[8:5], v[1], v[0]);
            endcase
        end
        @(negedge clk);
        idle();
        #1;
        check(10, "lq_empty after drain", lq_empty, 1'b1);
        check(10, "sq_empty after drain", sq_empty, 1'b1);

        // R9: zero store limit, physical depth of four
        do_reset();
        for (int t = 1; t <= 4; t++) do_alloc(9, TAG_W'(t), 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk); idle(); #1;
        check(9, "sq_full zero limit", sq_full, 1'b0);
        do_alloc(9, 4'd5, 1'b0, 1'b1, 1'b0, 1'b0);

        // R6 full barrier, R1 dual occupancy
        do_reset();
        do_alloc(6, 4'd1, 1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk); idle(); #1;
        check(1, "lq_empty dual", lq_empty, 1'b0);
        check(1, "sq_empty dual", sq_empty, 1'b0);
        do_alloc(6, 4'd2, 1'b1, 1'b0, 1'b0, 1'b1);
        do_alloc(6, 4'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        do_query(6, 4'd2, 1'b1, 1'b0);
        do_query(6, 4'd3, 1'b1, 1'b0);
        do_query(6, 4'd1, 1'b1, 1'b1);
        do_retire(6, 4'd1, 1'b0);
        do_query(6, 4'd2, 1'b1, 1'b1);
        do_query(3, 4'd3, 1'b1, 1'b0);

        // R12: allocation visible one cycle later
        do_reset();
        @(negedge clk);
        idle();
        alc_valid = 1'b1; alc_tag = 4'd5; alc_may_load = 1'b1;
        alc_may_store = 1'b0; alc_side_eff = 1'b0; qry_tag = 4'd5;
        #1 check(12, "qry_ready same cycle", qry_ready, 1'b0);
        do_query(12, 4'd5, 1'b0, 1'b1);

        // R10: allocate and retire together
        @(negedge clk);
        idle();
        alc_valid = 1'b1; alc_tag = 4'd6; alc_may_load = 1'b1;
        alc_may_store = 1'b0; alc_side_eff = 1'b0;
        ret_valid = 1'b1; ret_tag = 4'd5;
        #1 check(10, "grant with retire", alc_granted, 1'b1);
        do_query(10, 4'd6, 1'b0, 1'b1);
        check(10, "lq_full one held", lq_full, 1'b0);
        do_alloc(8, 4'd7, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk); idle(); #1;
        check(8, "lq_full at limit", lq_full, 1'b1);
        do_alloc(8, 4'd8, 1'b1, 1'b0, 1'b0, 1'b0);

        @(negedge clk);
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule